// File: doc/BRIEF.md
# Cache-Line Fetch Group Builder

This block sits at the front of an instruction fetch pipeline that runs several hardware threads. Each cycle a scheduler may grant one thread. The block gets that thread's PC and issues a request for the aligned cache line. In the same cycle the cache says whether it can take the request, the translation reports any fault, and the block receives the returned line along with per-word hints. The hints are a control-instruction bit, a predicted-taken bit with its target, and a quiesce bit. From these the block cuts a group of up to `FETCH_W` instructions. It tags each instruction with its own PC and a sequence number from a global counter, and it returns the PC at which the thread resumes.

A group stops at the first of these events: the line runs out, the fetch width is filled, a predicted-taken branch is emitted, or a quiesce instruction is emitted. A quiesce parks the thread. A translation fault also parks the thread, in a trap state. In that case no instructions go out, and the fault is reported with the sequence number that would have come next. A parked thread stays parked until a redirect for it arrives. A pending interrupt blocks new line requests, except while fetch runs in physical-address mode.

Top module: `fetch_group_builder`

## Requirements
- R1: When a running thread is granted and no request gate is active, `line_req` is high in that same cycle, and `line_addr` equals `go_pc` with its low log2(`LINE_BYTES`) bits cleared (bits 5:0 at the default 64 bytes).
- R2: The first slot takes the line word whose index is `go_pc` bits 5:2. Its PC is `go_pc`, and word k of `line_data` sits at bits [32k+31:32k].
- R3: Slots are filled from the start word toward the end of the line. Filling stops at the last word of the line or after `FETCH_W` slots, whichever comes first. The valid slots always form a prefix whose length is `grp_count`.
- R4: A word whose `ctrl_bits` and `taken_bits` are both 1 is emitted as the last slot of the group. The next PC is then that word's entry in `target_data`, with word k at bits [32k+31:32k]. A set taken bit on a word whose control bit is 0 has no effect.
- R5: Every other emitted word is followed by its own PC plus 4. `upd_pc` is the PC after the last emitted slot, and `upd_npc` equals `upd_pc` plus 4.
- R6: Slot i carries the sequence number (counter + i). After a group, the counter advances by `grp_count`.
- R7: A word with its `quiesce_bits` bit set is still emitted and ends the group. Its thread then shows `thread_halted` and issues no line request until it is redirected.
- R8: While `intr_pending` is 1 and `phys_mode` is 0, `line_req` stays 0 and no result is produced. With `phys_mode` at 1, fetch goes ahead normally.
- R9: If `fault_in` is high on an accepted request, `fault_out` pulses and no slot is valid. `fault_seq` equals the unadvanced counter, the counter does not move, and the thread shows `thread_trapped` and issues no line request until it is redirected.
- R10: When `cache_ready` is 0, the request produces no group and no fault, and the sequence counter keeps its value.
- R11: A `redirect` for a thread returns it to running from the next cycle on. A grant to the same thread in the cycle of its redirect is not taken.
- R12: Results appear the cycle after the accepting clock edge. `grp_valid` and `fault_out` are one-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Thread grant this cycle |
| go_tid | input | TID_W | Granted thread |
| go_pc | input | 32 | PC of the granted thread |
| phys_mode | input | 1 | Fetch runs in physical-address mode |
| intr_pending | input | 1 | Interrupt waiting to be taken |
| line_req | output | 1 | Cache line request |
| line_addr | output | 32 | Line-aligned request address |
| cache_ready | input | 1 | Cache accepts the request this cycle |
| fault_in | input | 1 | Translation or bad-address fault on the request |
| line_data | input | LINE_BYTES*8 | Returned cache line |
| ctrl_bits | input | LINE_BYTES/4 | Per-word control-instruction flag |
| taken_bits | input | LINE_BYTES/4 | Per-word predicted-taken flag |
| quiesce_bits | input | LINE_BYTES/4 | Per-word quiesce flag |
| target_data | input | LINE_BYTES*8 | Per-word predicted target |
| redirect | input | 1 | Return a parked thread to running |
| redirect_tid | input | TID_W | Thread being redirected |
| thread_halted | output | NT | Thread parked by a quiesce |
| thread_trapped | output | NT | Thread parked by a fault |
| grp_valid | output | 1 | Group result pulse |
| grp_tid | output | TID_W | Thread of the result |
| grp_count | output | CNT_W | Number of valid slots |
| slot_valid | output | FETCH_W | Per-slot valid |
| slot_inst | output | FETCH_W*32 | Per-slot instruction word |
| slot_pc | output | FETCH_W*32 | Per-slot PC |
| slot_seq | output | FETCH_W*SEQ_W | Per-slot sequence number |
| upd_pc | output | 32 | Resume PC for the thread |
| upd_npc | output | 32 | Resume PC plus 4 |
| fault_out | output | 1 | Fault result pulse |
| fault_seq | output | SEQ_W | Sequence number reported with the fault |

## Verification
`line_req` and `line_addr` are combinational. They are due in the grant cycle itself, so the bench reads them 1 ns after it drives the inputs on the falling edge. Every other result passes through exactly one register. The group, the fault pulse and the parked-thread flags are therefore due one cycle after the accepting rising edge, and the bench samples them on the falling edge that follows that edge. Pulse width is checked by sampling one falling edge later again, with the grant removed. The sequence counter has no port of its own, so its value is checked through the `slot_seq` of the next group a scenario produces.

// File: rtl/fgb_pkg.sv
package fgb_pkg;
  localparam int PC_W = 32;
  localparam int INST_BYTES = 4;

  typedef enum logic [1:0] {
    TH_RUN     = 2'd0,
    TH_QUIESCE = 2'd1,
    TH_TRAP    = 2'd2
  } th_state_e;

  // Line-aligned request address.
  function automatic logic [PC_W-1:0] line_base(input logic [PC_W-1:0] pc,
                                                input int unsigned line_bytes);
    return pc & ~PC_W'(line_bytes - 1);
  endfunction

  // Word index inside the line; the byte-within-word bits are dropped.
  function automatic int unsigned word_slot(input logic [PC_W-1:0] pc,
                                            input int unsigned line_bytes);
    return 32'((pc & PC_W'(line_bytes - 1)) >> 2);
  endfunction

  // Sequential successor of an instruction address.
  function automatic logic [PC_W-1:0] pc_succ(input logic [PC_W-1:0] pc);
    return pc + PC_W'(INST_BYTES);
  endfunction
endpackage

// File: rtl/fgb_slot_select.sv
module fgb_slot_select
  import fgb_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int FETCH_W    = 4,
  parameter int LINE_WORDS = LINE_BYTES / INST_BYTES,
  parameter int IDX_W      = $clog2(LINE_WORDS),
  parameter int CNT_W      = $clog2(FETCH_W + 1)
) (
  input  logic [PC_W-1:0]                pc,
  input  logic [LINE_WORDS*32-1:0]       line_data,
  input  logic [LINE_WORDS-1:0]          ctrl_bits,
  input  logic [LINE_WORDS-1:0]          taken_bits,
  input  logic [LINE_WORDS-1:0]          quiesce_bits,
  input  logic [LINE_WORDS*32-1:0]       target_data,
  output logic [FETCH_W-1:0]             sel_valid,
  output logic [FETCH_W-1:0][31:0]       sel_inst,
  output logic [FETCH_W-1:0][PC_W-1:0]   sel_pc,
  output logic [CNT_W-1:0]               sel_count,
  output logic [PC_W-1:0]                sel_next_pc,
  output logic                           sel_quiesce
);
  logic [IDX_W-1:0] start_idx;
  logic [IDX_W:0]   w;
  logic             stop;
  logic [PC_W-1:0]  cur;

  assign start_idx = IDX_W'(word_slot(pc, LINE_BYTES));

  // Serial walk: each slot inherits the stop condition of the one before it.
  always_comb begin
    stop        = 1'b0;
    cur         = pc;
    w           = '0;
    sel_count   = '0;
    sel_quiesce = 1'b0;
    for (int i = 0; i < FETCH_W; i++) begin
      w            = {1'b0, start_idx} + (IDX_W+1)'(i);
      sel_valid[i] = 1'b0;
      sel_inst[i]  = '0;
      sel_pc[i]    = '0;
      if (!stop && (w < (IDX_W+1)'(LINE_WORDS))) begin
        sel_valid[i] = 1'b1;
        sel_inst[i]  = line_data[32*w +: 32];
        sel_pc[i]    = cur;
        sel_count    = sel_count + CNT_W'(1);
        if (ctrl_bits[w[IDX_W-1:0]] && taken_bits[w[IDX_W-1:0]]) begin
          cur  = target_data[32*w +: 32];
          stop = 1'b1;
        end else begin
          cur = pc_succ(cur);
        end
        if (quiesce_bits[w[IDX_W-1:0]]) begin
          sel_quiesce = 1'b1;
          stop        = 1'b1;
        end
      end else begin
        stop = 1'b1;
      end
    end
    sel_next_pc = cur;
  end
endmodule

// File: rtl/fgb_thread_ctl.sv
module fgb_thread_ctl
  import fgb_pkg::*;
#(
  parameter int NT    = 4,
  parameter int TID_W = $clog2(NT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_quiesce,
  input  logic             set_trap,
  input  logic [TID_W-1:0] upd_tid,
  input  logic             redirect,
  input  logic [TID_W-1:0] redirect_tid,
  output logic [NT-1:0]    running,
  output logic [NT-1:0]    halted,
  output logic [NT-1:0]    trapped
);
  for (genvar t = 0; t < NT; t++) begin : g_th
    th_state_e st;
    logic      redir_hit;
    logic      upd_hit;

    assign redir_hit = redirect && (redirect_tid == TID_W'(t));
    assign upd_hit   = upd_tid == TID_W'(t);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st <= TH_RUN;
      end else if (redir_hit) begin
        st <= TH_RUN;
      end else if (upd_hit && set_trap) begin
        st <= TH_TRAP;
      end else if (upd_hit && set_quiesce) begin
        st <= TH_QUIESCE;
      end
    end

    assign running[t] = (st == TH_RUN);
    assign halted[t]  = (st == TH_QUIESCE);
    assign trapped[t] = (st == TH_TRAP);

    AST_REDIRECT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      redir_hit |=> running[t]); // R11
    AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      trapped[t] && !redir_hit |=> trapped[t]); // R9
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      halted[t] && !redir_hit |=> halted[t]); // R7
  end
endmodule

// File: rtl/fetch_group_builder.sv
module fetch_group_builder
  import fgb_pkg::*;
#(
  parameter int NT         = 4,
  parameter int LINE_BYTES = 64,
  parameter int FETCH_W    = 4,
  parameter int SEQ_W      = 16,
  localparam int TID_W      = $clog2(NT),
  localparam int LINE_WORDS = LINE_BYTES / INST_BYTES,
  localparam int CNT_W      = $clog2(FETCH_W + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go,
  input  logic [TID_W-1:0]            go_tid,
  input  logic [31:0]                 go_pc,
  input  logic                        phys_mode,
  input  logic                        intr_pending,
  output logic                        line_req,
  output logic [31:0]                 line_addr,
  input  logic                        cache_ready,
  input  logic                        fault_in,
  input  logic [LINE_BYTES*8-1:0]     line_data,
  input  logic [LINE_WORDS-1:0]       ctrl_bits,
  input  logic [LINE_WORDS-1:0]       taken_bits,
  input  logic [LINE_WORDS-1:0]       quiesce_bits,
  input  logic [LINE_BYTES*8-1:0]     target_data,
  input  logic                        redirect,
  input  logic [TID_W-1:0]            redirect_tid,
  output logic [NT-1:0]               thread_halted,
  output logic [NT-1:0]               thread_trapped,
  output logic                        grp_valid,
  output logic [TID_W-1:0]            grp_tid,
  output logic [CNT_W-1:0]            grp_count,
  output logic [FETCH_W-1:0]          slot_valid,
  output logic [FETCH_W*32-1:0]       slot_inst,
  output logic [FETCH_W*32-1:0]       slot_pc,
  output logic [FETCH_W*SEQ_W-1:0]    slot_seq,
  output logic [31:0]                 upd_pc,
  output logic [31:0]                 upd_npc,
  output logic                        fault_out,
  output logic [SEQ_W-1:0]            fault_seq
);
  // Named internal events
  logic                          grant_ok;
  logic                          intr_block;
  logic                          accept;
  logic                          take_fault;
  logic                          take_group;
  logic [NT-1:0]                 running;
  logic [SEQ_W-1:0]              seq_q;

  logic [FETCH_W-1:0]            sel_valid;
  logic [FETCH_W-1:0][31:0]      sel_inst;
  logic [FETCH_W-1:0][PC_W-1:0]  sel_pc;
  logic [CNT_W-1:0]              sel_count;
  logic [PC_W-1:0]               sel_next_pc;
  logic                          sel_quiesce;

  assign grant_ok   = go && running[go_tid] && !(redirect && (redirect_tid == go_tid));
  assign intr_block = intr_pending && !phys_mode;
  assign line_req   = grant_ok && !intr_block;
  assign line_addr  = line_base(go_pc, LINE_BYTES);
  assign accept     = line_req && cache_ready;
  assign take_fault = accept && fault_in;
  assign take_group = accept && !fault_in;

  fgb_slot_select #(
    .LINE_BYTES (LINE_BYTES),
    .FETCH_W    (FETCH_W)
  ) u_sel (
    .pc           (go_pc),
    .line_data    (line_data),
    .ctrl_bits    (ctrl_bits),
    .taken_bits   (taken_bits),
    .quiesce_bits (quiesce_bits),
    .target_data  (target_data),
    .sel_valid    (sel_valid),
    .sel_inst     (sel_inst),
    .sel_pc       (sel_pc),
    .sel_count    (sel_count),
    .sel_next_pc  (sel_next_pc),
    .sel_quiesce  (sel_quiesce)
  );

  fgb_thread_ctl #(.NT(NT)) u_thr (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_quiesce  (take_group && sel_quiesce),
    .set_trap     (take_fault),
    .upd_tid      (go_tid),
    .redirect     (redirect),
    .redirect_tid (redirect_tid),
    .running      (running),
    .halted       (thread_halted),
    .trapped      (thread_trapped)
  );

  // Global sequence counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q <= '0;
    end else if (take_group) begin
      seq_q <= seq_q + SEQ_W'(sel_count);
    end
  end

  // Result register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_valid  <= 1'b0;
      fault_out  <= 1'b0;
      grp_tid    <= '0;
      grp_count  <= '0;
      slot_valid <= '0;
      slot_inst  <= '0;
      slot_pc    <= '0;
      slot_seq   <= '0;
      upd_pc     <= '0;
      upd_npc    <= '0;
      fault_seq  <= '0;
    end else begin
      grp_valid  <= take_group;
      fault_out  <= take_fault;
      slot_valid <= take_group ? sel_valid : '0;
      grp_count  <= take_group ? sel_count : '0;
      if (accept) begin
        grp_tid <= go_tid;
      end
      if (take_group) begin
        for (int i = 0; i < FETCH_W; i++) begin
          slot_inst[32*i +: 32]       <= sel_inst[i];
          slot_pc[32*i +: 32]         <= sel_pc[i];
          slot_seq[SEQ_W*i +: SEQ_W]  <= seq_q + SEQ_W'(i);
        end
        upd_pc  <= sel_next_pc;
        upd_npc <= pc_succ(sel_next_pc);
      end
      if (take_fault) begin
        fault_seq <= seq_q;
      end
    end
  end

  AST_INTR_GATES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    intr_block |-> !line_req); // R8
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> seq_q == $past(seq_q) + SEQ_W'(grp_count)); // R6
  AST_FAULT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_out |-> (slot_valid == '0) && !grp_valid); // R9
  AST_FAULT_SEQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fault_out |-> fault_seq == seq_q); // R9
  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    line_req && !cache_ready |=> !grp_valid && !fault_out); // R10
  AST_SLOT_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> slot_valid == FETCH_W'((1 << grp_count) - 1)); // R3
  AST_PARKED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    go && (thread_halted[go_tid] || thread_trapped[go_tid]) |-> !line_req); // R7
endmodule

// File: tb/fetch_group_builder_tb.sv
module fetch_group_builder_tb;
  localparam int NT = 4;
  localparam int LB = 64;
  localparam int FW = 4;
  localparam int SW = 16;
  localparam int LW = LB / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [1:0] go_tid = '0;
  logic [31:0] go_pc = '0;
  logic phys_mode = 1'b0, intr_pending = 1'b0, cache_ready = 1'b1, fault_in = 1'b0;
  logic line_req;
  logic [31:0] line_addr;
  logic [LB*8-1:0] line_data, target_data;
  logic [LW-1:0] ctrl_bits = '0, taken_bits = '0, quiesce_bits = '0;
  logic redirect = 1'b0;
  logic [1:0] redirect_tid = '0;
  logic [NT-1:0] thread_halted, thread_trapped;
  logic grp_valid;
  logic [1:0] grp_tid;
  logic [2:0] grp_count;
  logic [FW-1:0] slot_valid;
  logic [FW*32-1:0] slot_inst, slot_pc;
  logic [FW*SW-1:0] slot_seq;
  logic [31:0] upd_pc, upd_npc;
  logic fault_out;
  logic [SW-1:0] fault_seq;

  int n_tests = 0;
  int n_fail = 0;
  int exp_seq = 0;
  logic got_req;
  logic [31:0] got_addr;

  always #10 clk = ~clk;

  fetch_group_builder u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .go_tid(go_tid), .go_pc(go_pc),
    .phys_mode(phys_mode), .intr_pending(intr_pending), .line_req(line_req),
    .line_addr(line_addr), .cache_ready(cache_ready), .fault_in(fault_in),
    .line_data(line_data), .ctrl_bits(ctrl_bits), .taken_bits(taken_bits),
    .quiesce_bits(quiesce_bits), .target_data(target_data), .redirect(redirect),
    .redirect_tid(redirect_tid), .thread_halted(thread_halted),
    .thread_trapped(thread_trapped), .grp_valid(grp_valid), .grp_tid(grp_tid),
    .grp_count(grp_count), .slot_valid(slot_valid), .slot_inst(slot_inst),
    .slot_pc(slot_pc), .slot_seq(slot_seq), .upd_pc(upd_pc), .upd_npc(upd_npc),
    .fault_out(fault_out), .fault_seq(fault_seq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One grant: inputs on the falling edge, combinational request read 1 ns
  // later, registered results valid on the next falling edge.
  task automatic grant(input logic [1:0] tid, input logic [31:0] pc,
                       input logic ph, input logic ip, input logic rdy, input logic flt);
    @(negedge clk);
    go = 1'b1; go_tid = tid; go_pc = pc;
    phys_mode = ph; intr_pending = ip; cache_ready = rdy; fault_in = flt;
    #1;
    got_req = line_req;
    got_addr = line_addr;
    @(negedge clk);
    go = 1'b0; phys_mode = 1'b0; intr_pending = 1'b0; cache_ready = 1'b1; fault_in = 1'b0;
  endtask

  task automatic do_redirect(input logic [1:0] tid);
    @(negedge clk);
    redirect = 1'b1; redirect_tid = tid;
    @(negedge clk);
    redirect = 1'b0;
  endtask

  // Independent model of the group built from the current line and hints.
  task automatic check_group(input string req, input logic [1:0] tid, input logic [31:0] pc);
    int idx, n;
    logic [31:0] p;
    logic [31:0] e_pc [FW];
    int e_w [FW];
    idx = (pc % LB) / 4;
    p = pc;
    n = 0;
    while (n < FW && idx < LW) begin
      e_pc[n] = p; e_w[n] = idx; n++;
      if (ctrl_bits[idx] && taken_bits[idx]) begin
        p = target_data[32*idx +: 32];
        break;
      end
      p = p + 4;
      if (quiesce_bits[idx]) break;
      idx++;
    end
    chk(grp_valid === 1'b1, req, "grp_valid", 64'(grp_valid), 1);
    chk(grp_tid === tid, req, "grp_tid", 64'(grp_tid), 64'(tid));
    chk(grp_count === 3'(n), req, "grp_count", 64'(grp_count), 64'(n));
    for (int i = 0; i < n; i++) begin
      chk(slot_valid[i] === 1'b1, req, "slot_valid", 64'(slot_valid), 64'(i));
      chk(slot_inst[32*i +: 32] === (32'hA000_0000 + 32'(e_w[i])), req, "slot_inst",
          64'(slot_inst[32*i +: 32]), 64'(32'hA000_0000 + 32'(e_w[i])));
      chk(slot_pc[32*i +: 32] === e_pc[i], req, "slot_pc", 64'(slot_pc[32*i +: 32]), 64'(e_pc[i]));
      chk(slot_seq[SW*i +: SW] === SW'(exp_seq + i), req, "slot_seq (R6)",
          64'(slot_seq[SW*i +: SW]), 64'(SW'(exp_seq + i)));
    end
    for (int i = n; i < FW; i++)
      chk(slot_valid[i] === 1'b0, req, "slot beyond end (R3)", 64'(slot_valid), 64'(i));
    chk(upd_pc === p, req, "upd_pc (R5)", 64'(upd_pc), 64'(p));
    chk(upd_npc === p + 32'd4, req, "upd_npc (R5)", 64'(upd_npc), 64'(p + 32'd4));
    exp_seq = exp_seq + n;
  endtask

  task automatic t_reset;
    chk(grp_valid === 1'b0 && fault_out === 1'b0, "R12", "reset pulses", 64'({grp_valid, fault_out}), 0);
    chk(thread_halted === '0 && thread_trapped === '0, "R11", "reset thread state",
        64'({thread_halted, thread_trapped}), 0);
    chk(line_req === 1'b0, "R1", "idle line_req", 64'(line_req), 0);
  endtask

  task automatic t_plain;
    ctrl_bits = '0; taken_bits = '0; quiesce_bits = '0;
    grant(2'd0, 32'h0000_1008, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(got_req === 1'b1, "R1", "line_req", 64'(got_req), 1);
    chk(got_addr === 32'h0000_1000, "R1", "line_addr", 64'(got_addr), 64'h1000);
    check_group("R2", 2'd0, 32'h0000_1008);
    @(negedge clk);
    chk(grp_valid === 1'b0, "R12", "pulse width", 64'(grp_valid), 0);
  endtask

  task automatic t_line_end;
    ctrl_bits = '0; taken_bits = '0; quiesce_bits = '0;
    grant(2'd1, 32'h0000_2034, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(got_addr === 32'h0000_2000, "R1", "line_addr end", 64'(got_addr), 64'h2000);
    check_group("R3", 2'd1, 32'h0000_2034);
  endtask

  task automatic t_taken;
    ctrl_bits = '0; taken_bits = '0; quiesce_bits = '0;
    ctrl_bits[1] = 1'b1; taken_bits[1] = 1'b1;
    grant(2'd2, 32'h0000_3000, 1'b0, 1'b0, 1'b1, 1'b0);
    check_group("R4", 2'd2, 32'h0000_3000);
    chk(upd_pc === 32'h0000_8040, "R4", "taken target", 64'(upd_pc), 64'h8040);
    // Taken hint on a non-control word is ignored; not-taken control falls through.
    ctrl_bits = '0; taken_bits = '0;
    taken_bits[4] = 1'b1; ctrl_bits[5] = 1'b1;
    grant(2'd2, 32'h0000_3010, 1'b0, 1'b0, 1'b1, 1'b0);
    check_group("R4", 2'd2, 32'h0000_3010);
    chk(grp_count === 3'd4, "R5", "fall-through count", 64'(grp_count), 4);
  endtask

  task automatic t_intr;
    ctrl_bits = '0; taken_bits = '0; quiesce_bits = '0;
    grant(2'd0, 32'h0000_4000, 1'b0, 1'b1, 1'b1, 1'b0);
    chk(got_req === 1'b0, "R8", "blocked line_req", 64'(got_req), 0);
    chk(grp_valid === 1'b0, "R8", "blocked group", 64'(grp_valid), 0);
    grant(2'd0, 32'h0000_4000, 1'b1, 1'b1, 1'b1, 1'b0);
    chk(got_req === 1'b1, "R8", "physical line_req", 64'(got_req), 1);
    check_group("R8", 2'd0, 32'h0000_4000);
  endtask

  task automatic t_not_ready;
    grant(2'd3, 32'h0000_5000, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(got_req === 1'b1, "R10", "request raised", 64'(got_req), 1);
    chk(grp_valid === 1'b0 && fault_out === 1'b0, "R10", "no result",
        64'({grp_valid, fault_out}), 0);
    grant(2'd3, 32'h0000_5000, 1'b0, 1'b0, 1'b1, 1'b0);
    check_group("R10", 2'd3, 32'h0000_5000);
  endtask

  task automatic t_fault;
    grant(2'd1, 32'h0000_6000, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(fault_out === 1'b1, "R9", "fault_out", 64'(fault_out), 1);
    chk(slot_valid === '0 && grp_valid === 1'b0, "R9", "no slots", 64'(slot_valid), 0);
    chk(fault_seq === SW'(exp_seq), "R9", "fault_seq", 64'(fault_seq), 64'(exp_seq));
    chk(thread_trapped === 4'b0010, "R9", "trapped", 64'(thread_trapped), 2);
    grant(2'd1, 32'h0000_6000, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(got_req === 1'b0, "R9", "trapped line_req", 64'(got_req), 0);
    do_redirect(2'd1);
    chk(thread_trapped === 4'b0000, "R11", "redirect clears trap", 64'(thread_trapped), 0);
    grant(2'd1, 32'h0000_6000, 1'b0, 1'b0, 1'b1, 1'b0);
    check_group("R9", 2'd1, 32'h0000_6000);
  endtask

  task automatic t_quiesce;
    ctrl_bits = '0; taken_bits = '0; quiesce_bits = '0;
    quiesce_bits[2] = 1'b1;
    grant(2'd1, 32'h0000_7000, 1'b0, 1'b0, 1'b1, 1'b0);
    check_group("R7", 2'd1, 32'h0000_7000);
    chk(grp_count === 3'd3, "R7", "quiesce emitted", 64'(grp_count), 3);
    chk(thread_halted === 4'b0010, "R7", "halted", 64'(thread_halted), 2);
    quiesce_bits = '0;
    grant(2'd1, 32'h0000_7100, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(got_req === 1'b0 && grp_valid === 1'b0, "R7", "halted silent",
        64'({got_req, grp_valid}), 0);
    grant(2'd0, 32'h0000_7100, 1'b0, 1'b0, 1'b1, 1'b0);
    check_group("R7", 2'd0, 32'h0000_7100);
    do_redirect(2'd1);
    chk(thread_halted === 4'b0000, "R11", "redirect clears halt", 64'(thread_halted), 0);
  endtask

  initial begin
    for (int k = 0; k < LW; k++) begin
      line_data[32*k +: 32]   = 32'hA000_0000 + 32'(k);
      target_data[32*k +: 32] = 32'h0000_8000 + 32'(k) * 32'h40;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_line_end();
    t_taken();
    t_intr();
    t_not_ready();
    t_fault();
    t_quiesce();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule